// File: doc/BRIEF.md
# Broadcast Clock Resynchronization Node

This block is one node of a fault-tolerant group of processors that keep their local time counters aligned by periodic resynchronization. A free-running local counter advances once per clock. Each time it reaches the scheduled resynchronization time, the node runs a fixed sequence of transmit windows, one for each node of the group and taken in slot order. In the window that belongs to this node, it broadcasts its own counter value. In every other window, it listens for the value broadcast by that window's owner.

When a remote value arrives, the node latches its own counter in the same cycle, with no polling delay. It turns the pair into an apparent skew by adding a configured expected transit delay. A window that closes without any arrival marks its owner as missing. After the last window, the node takes the median of the skews it collected, together with a zero for itself. It adds that median straight into the counter, so the next resynchronization point, which is measured in local time, moves with the correction.

Window length, transit delay and resynchronization period are static configuration inputs. The configured period must be longer than the whole sequence of windows plus one cycle.

Top module: `csn_node`

## Requirements
- R1: `local_time` is 0 during reset. Outside the correction cycle it grows by exactly one per clock, modulo 2^TW.
- R2: `resync` pulses when `local_time` reaches the scheduled time. The first scheduled time after reset is 1. Each later one is the previous scheduled time plus `cfg_period`.
- R3: After `resync`, NODES windows follow in slot order 0 to NODES-1, each `cfg_win_len` cycles long, with `win_active` high and `win_slot` giving the slot. `corr_valid` is high in the single cycle right after the last window.
- R4: In the first cycle of slot MY_ID, `tx_valid` is high and `tx_data` equals `local_time` of that cycle. `tx_valid` is low in every other cycle.
- R5: In a slot other than MY_ID, the first cycle with `rx_valid` high records that slot's skew as `rx_data + cfg_delay - local_time`, taking `local_time` from the same cycle and treating the result as a TW-bit two's complement value.
- R6: Arrivals after the first one in the same window, and arrivals during slot MY_ID, do not change the correction.
- R7: A slot whose window passes with no arrival is left out of the correction.
- R8: `corr_value` is the lower median of the set made of the recorded skews plus one zero for the node itself. The set is sorted ascending and the element at index floor((k-1)/2) is taken, where k is the set size.
- R9: In the cycle after `corr_valid`, `local_time` equals the previous `local_time` plus 1 plus `corr_value`.
- R10: `resync` never rises while windows or the correction cycle are in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter ticks on each rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_period | input | TW | Resynchronization period in local ticks |
| cfg_win_len | input | WLW | Length of each window in cycles (at least 1) |
| cfg_delay | input | TW | Expected transit delay added to each remote value |
| rx_valid | input | 1 | A broadcast value from the current slot owner is present |
| rx_data | input | TW | Received remote counter value |
| tx_valid | output | 1 | This node is broadcasting this cycle |
| tx_data | output | TW | Value being broadcast |
| local_time | output | TW | Local time counter |
| resync | output | 1 | Resynchronization event pulse |
| win_active | output | 1 | A window is open |
| win_slot | output | IW | Index of the open window's owner |
| corr_valid | output | 1 | Correction is applied this cycle |
| corr_value | output | TW | Signed correction being applied |

## Verification
The checker watches every cycle for the plain counter step, for the jump by exactly the reported correction, and for single-cycle broadcast and correction pulses. It also checks that each event is followed by slot 0 and that the correction comes straight after the last slot. Whether the correction is the right median of the right skews, with late, duplicate and own-slot arrivals ignored and missing nodes left out, can only be shown by the bench scenarios. The same holds for whether the next event lands exactly one period later in corrected time. These depend on values the bench chooses per window and compares with its own model.

// File: rtl/csn_pkg.sv
package csn_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WIN  = 2'd1,
        PH_CORR = 2'd2
    } csn_phase_e;
endpackage

// File: rtl/csn_skew.sv
module csn_skew #(
    parameter int TW = 16
) (
    input  logic [TW-1:0] remote_val,
    input  logic [TW-1:0] transit,
    input  logic [TW-1:0] local_now,
    output logic [TW-1:0] skew
);
    // apparent offset of the remote clock relative to the latched local count
    assign skew = remote_val + transit - local_now;
endmodule

// File: rtl/csn_median.sv
module csn_median #(
    parameter int N = 4,
    parameter int W = 16
) (
    input  logic [N*W-1:0] vals,
    input  logic [N-1:0]   vld,
    output logic [W-1:0]   med
);
    localparam int CW = $clog2(N + 1);

    // rank every valid entry (ties broken by index) and pick the lower-middle rank
    always_comb begin
        logic [CW-1:0]       cnt;
        logic [CW-1:0]       tgt;
        logic [CW-1:0]       rank;
        logic signed [W-1:0] vj;
        logic signed [W-1:0] vk;
        cnt = '0;
        for (int j = 0; j < N; j++) begin
            if (vld[j]) cnt = cnt + CW'(1);
        end
        tgt = (cnt - CW'(1)) >> 1;
        med = '0;
        for (int j = 0; j < N; j++) begin
            vj   = vals[j*W +: W];
            rank = '0;
            for (int k = 0; k < N; k++) begin
                vk = vals[k*W +: W];
                if (vld[k] && ((vk < vj) || ((vk == vj) && (k < j))))
                    rank = rank + CW'(1);
            end
            if (vld[j] && (rank == tgt)) med = vj;
        end
    end
endmodule

// File: rtl/csn_node.sv
module csn_node
    import csn_pkg::*;
#(
    parameter int NODES = 4,
    parameter int MY_ID = 2,
    parameter int TW    = 16,
    parameter int WLW   = 8,
    localparam int IW   = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [TW-1:0]  cfg_period,
    input  logic [WLW-1:0] cfg_win_len,
    input  logic [TW-1:0]  cfg_delay,
    input  logic           rx_valid,
    input  logic [TW-1:0]  rx_data,
    output logic           tx_valid,
    output logic [TW-1:0]  tx_data,
    output logic [TW-1:0]  local_time,
    output logic           resync,
    output logic           win_active,
    output logic [IW-1:0]  win_slot,
    output logic           corr_valid,
    output logic [TW-1:0]  corr_value
);
    localparam logic [IW-1:0] OWN_SLOT  = IW'(MY_ID);
    localparam logic [IW-1:0] LAST_SLOT = IW'(NODES - 1);

    typedef struct packed {
        csn_phase_e        phase;
        logic [IW-1:0]     slot;
        logic [WLW-1:0]    tmr;
        logic [TW-1:0]     cnt;
        logic [TW-1:0]     due;
        logic [NODES-1:0]  got;
        logic [NODES*TW-1:0] skw;
    } node_st_t;

    node_st_t st_d, st_q;

    logic [TW-1:0] skew_now;
    logic [TW-1:0] med;
    logic [TW-1:0] due_diff;
    logic          due_now;

    csn_skew #(.TW(TW)) u_skew (
        .remote_val (rx_data),
        .transit    (cfg_delay),
        .local_now  (st_q.cnt),
        .skew       (skew_now)
    );

    csn_median #(.N(NODES), .W(TW)) u_med (
        .vals (st_q.skw),
        .vld  (st_q.got),
        .med  (med)
    );

    assign due_diff = st_q.cnt - st_q.due;
    assign due_now  = (st_q.phase == PH_IDLE) && !due_diff[TW-1];

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + TW'(1);
        case (st_q.phase)
            PH_IDLE: begin
                if (due_now) begin
                    st_d.phase        = PH_WIN;
                    st_d.slot         = '0;
                    st_d.tmr          = '0;
                    st_d.due          = st_q.due + cfg_period;
                    st_d.got          = '0;
                    st_d.got[MY_ID]   = 1'b1;
                    st_d.skw          = '0;
                end
            end
            PH_WIN: begin
                if (rx_valid && (st_q.slot != OWN_SLOT) && !st_q.got[st_q.slot]) begin
                    st_d.got[st_q.slot]          = 1'b1;
                    st_d.skw[st_q.slot*TW +: TW] = skew_now;
                end
                if (st_q.tmr == cfg_win_len - WLW'(1)) begin
                    st_d.tmr = '0;
                    if (st_q.slot == LAST_SLOT) st_d.phase = PH_CORR;
                    else                        st_d.slot  = st_q.slot + IW'(1);
                end else begin
                    st_d.tmr = st_q.tmr + WLW'(1);
                end
            end
            PH_CORR: begin
                st_d.cnt   = st_q.cnt + TW'(1) + med;
                st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.slot  <= '0;
            st_q.tmr   <= '0;
            st_q.cnt   <= '0;
            st_q.due   <= TW'(1);
            st_q.got   <= '0;
            st_q.skw   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign local_time = st_q.cnt;
    assign resync     = due_now;
    assign win_active = (st_q.phase == PH_WIN);
    assign win_slot   = st_q.slot;
    assign tx_valid   = (st_q.phase == PH_WIN) && (st_q.slot == OWN_SLOT) && (st_q.tmr == '0);
    assign tx_data    = st_q.cnt;
    assign corr_valid = (st_q.phase == PH_CORR);
    assign corr_value = med;
endmodule

// File: rtl/csn_node_chk.sv
module csn_node_chk #(
    parameter int NODES = 4,
    parameter int MY_ID = 2,
    parameter int TW    = 16,
    parameter int IW    = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_valid,
    input logic [TW-1:0] local_time,
    input logic          resync,
    input logic          win_active,
    input logic [IW-1:0] win_slot,
    input logic          corr_valid,
    input logic [TW-1:0] corr_value
);
    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !corr_valid |=> local_time == TW'($past(local_time) + TW'(1)));

    a_r9_corr_apply: assert property (@(posedge clk) disable iff (!rst_n)
        corr_valid |=> local_time == TW'($past(local_time) + TW'(1) + $past(corr_value)));

    a_r10_resync_opens: assert property (@(posedge clk) disable iff (!rst_n)
        resync |=> win_active && (win_slot == '0) && !resync);

    a_r4_tx_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !tx_valid);

    a_r3_corr_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        corr_valid |-> $past(win_active) && ($past(win_slot) == IW'(NODES - 1)));

    a_r8_corr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        corr_valid |=> !corr_valid && !win_active);
endmodule

bind csn_node csn_node_chk #(.NODES(NODES), .MY_ID(MY_ID), .TW(TW), .IW(IW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_valid   (tx_valid),
    .local_time (local_time),
    .resync     (resync),
    .win_active (win_active),
    .win_slot   (win_slot),
    .corr_valid (corr_valid),
    .corr_value (corr_value)
);

// File: tb/csn_node_tb.sv
module csn_node_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NODES = 4;
    localparam int MY_ID = 2;
    localparam int TW    = 16;
    localparam int WLW   = 8;
    localparam int IW    = 2;
    localparam int WL    = 8;
    localparam int PER   = 100;
    localparam int DLY   = 3;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [TW-1:0]  cfg_period;
    logic [WLW-1:0] cfg_win_len;
    logic [TW-1:0]  cfg_delay;
    logic           rx_valid;
    logic [TW-1:0]  rx_data;
    logic           tx_valid;
    logic [TW-1:0]  tx_data;
    logic [TW-1:0]  local_time;
    logic           resync;
    logic           win_active;
    logic [IW-1:0]  win_slot;
    logic           corr_valid;
    logic [TW-1:0]  corr_value;

    int total = 0;
    int bad   = 0;
    int exp_evt;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csn_node #(.NODES(NODES), .MY_ID(MY_ID), .TW(TW), .WLW(WLW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_win_len(cfg_win_len),
        .cfg_delay(cfg_delay), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .local_time(local_time),
        .resync(resync), .win_active(win_active), .win_slot(win_slot),
        .corr_valid(corr_valid), .corr_value(corr_value)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    function automatic int exp_med(input int d[NODES], input bit p[NODES]);
        int a[NODES];
        int n = 0;
        int t;
        for (int i = 0; i < NODES; i++) begin
            if (i == MY_ID) begin a[n] = 0; n++; end
            else if (p[i]) begin a[n] = d[i]; n++; end
        end
        for (int i = 0; i < n; i++)
            for (int j = 0; j + 1 < n - i; j++)
                if (a[j] > a[j+1]) begin t = a[j]; a[j] = a[j+1]; a[j+1] = t; end
        return a[(n-1)/2];
    endfunction

    // mode 0 random, 1 nobody answers, 2 window edges, 3 duplicate and own-slot pulses
    task automatic run_round(input int mode);
        int  d[NODES];
        bit  p[NODES];
        int  offs[NODES];
        bit  dup;
        bit  seen;
        int  prev_t, lt, cv, em;
        seen = 0;
        dup  = (mode == 3);
        for (int i = 0; i < NODES; i++) begin
            case (mode)
                1: begin p[i] = 0; d[i] = 0; offs[i] = 0; end
                2: begin p[i] = 1; d[i] = (i == 0) ? -7 : (i == 1 ? 11 : -3); offs[i] = (i == 0) ? 0 : WL-1; end
                3: begin p[i] = 1; d[i] = (i == 0) ? 9 : (i == 1 ? -4 : 6); offs[i] = 2; end
                default: begin
                    p[i] = ($urandom_range(0, 3) != 0);
                    d[i] = int'($urandom_range(0, 40)) - 20;
                    offs[i] = int'($urandom_range(0, WL-1));
                end
            endcase
        end
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (resync) begin seen = 1; break; end
        end
        chk(seen, "R2 resync seen", int'(seen), 1);
        chk(int'(local_time) == exp_evt, "R2 resync time", int'(local_time), exp_evt);
        exp_evt = exp_evt + PER;
        prev_t = int'(local_time);
        for (int s = 0; s < NODES; s++) begin
            for (int k = 0; k < WL; k++) begin
                @(negedge clk);
                rx_valid = 1'b0;
                chk(win_active && int'(win_slot) == s, "R3 slot order", int'(win_slot), s);
                chk(!resync, "R10 no resync in sequence", int'(resync), 0);
                chk(int'(local_time) == prev_t + 1, "R1 step", int'(local_time), prev_t + 1);
                prev_t = int'(local_time);
                if (s == MY_ID && k == 0) begin
                    chk(tx_valid && tx_data == local_time, "R4 broadcast", int'(tx_data), int'(local_time));
                end else begin
                    chk(!tx_valid, "R4 quiet", int'(tx_valid), 0);
                end
                if (s != MY_ID && p[s] && k == offs[s]) begin
                    rx_valid = 1'b1;
                    rx_data  = TW'(int'(local_time) + d[s] - DLY);
                end else if (s != MY_ID && p[s] && dup && k == offs[s] + 1) begin
                    rx_valid = 1'b1;  // R6 late duplicate with a far value
                    rx_data  = TW'(int'(local_time) + d[s] + 50 - DLY);
                end else if (s == MY_ID && mode != 1 && k == 3) begin
                    rx_valid = 1'b1;  // R6 own-slot arrival
                    rx_data  = TW'(int'(local_time) + 333);
                end
            end
        end
        @(negedge clk);
        rx_valid = 1'b0;
        em = exp_med(d, p);
        cv = int'($signed(corr_value));
        chk(corr_valid, "R3 correction follows last window", int'(corr_valid), 1);
        chk(cv == em, "R8 R5 R7 median", cv, em);
        lt = int'(local_time);
        @(negedge clk);
        chk(int'(local_time) == ((lt + 1 + cv) & 16'hFFFF), "R9 counter corrected", int'(local_time), (lt + 1 + cv) & 16'hFFFF);
        chk(!corr_valid, "R8 single correction pulse", int'(corr_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R3 watchdog: actual=%0d expected=%0d", 0, 1);
            report();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        cfg_period  = TW'(PER);
        cfg_win_len = WLW'(WL);
        cfg_delay   = TW'(DLY);
        rx_valid    = 1'b0;
        rx_data     = '0;
        rst_n       = 1'b0;
        repeat (3) @(negedge clk);
        chk(local_time == '0, "R1 reset time", int'(local_time), 0);
        chk(!tx_valid && !corr_valid && !win_active, "R1 reset outputs quiet", int'(tx_valid), 0);
        chk(!resync, "R2 no event in reset", int'(resync), 0);
        rst_n   = 1'b1;
        exp_evt = 1;
        run_round(1);
        run_round(2);
        run_round(3);
        for (int r = 0; r < 10; r++) run_round(0);
        finished = 1;
        report();
        $finish;
    end
endmodule